// File: doc/BRIEF.md
# Path-Message Data-Link Frame Receiver

This block recovers short data-link messages from a serial overhead channel that carries one bit per line frame. A bit arrives on `rx_bit` in each cycle in which `rx_valid` is high. The receiver finds the 0x7E flag octets that open and close each message, drops the zero bits the sender inserted after runs of five ones, and builds octets LSB first. It then checks the message: three fixed header octets, a message-type octet that sets the payload length, and a 16-bit frame check sequence.

When a message passes every check, its payload goes into an 82-byte buffer that the host reads by address, a message-received status bit is latched, and an interrupt can be raised. A message that fails any check sets an error bit instead. While the host has not yet taken an accepted message, the buffer is locked and later messages are ignored.

The host sees two byte-wide registers, a control register and a status register, through simple read and write strobes. Status bits clear when they are read.

Top module: `lapd_msg_rx`

## Requirements
- R1: While the enable bit (control bit 2) is 0, the receiver ignores the line. Flags and messages sent then change no status bit.
- R2: Each detected flag octet (bits 0,1,1,1,1,1,1,0 on the line) sets status bit 0. Reading the status register (address 1) clears status bits 0 to 2, and status bits 7 to 3 read as 0.
- R3: Inside a message, a 0 that follows five consecutive 1s is removed. Payload octets 0x7E and 0xFF are therefore received intact. Octets are assembled LSB first.
- R4: The first octet after the opening flag must be 0x3C or 0x3E, the second 0x01 and the third 0x03. Any other value rejects the message.
- R5: The fourth octet is the message type and is also payload byte 0. Types 0x38, 0x34 and 0x32 require exactly 76 payload bytes, and 0x3F requires exactly 82. An unknown type or a payload of the wrong length rejects the message.
- R6: The check sequence is CRC-16 with generator x^16+x^12+x^5+1, preset to 0xFFFF, processed LSB first and sent complemented with its low octet first. A message is good only if the register holds 0xF0B8 after the two check octets.
- R7: Seven or more consecutive 1s abort the current message. If at least one octet had been received, the abort counts as a rejection.
- R8: A good message sets status bit 1 and places payload byte i at buffer address i. A rejected message sets status bit 2 and not bit 1.
- R9: When control bit 1 (interrupt enable) is 1, an accepted message sets control bit 0 and drives `irq` high. Reading the control register (address 0) clears both.
- R10: The control register resets to 0x00. Bits 2 and 1 are writable, bit 0 ignores writes, and bits 7 to 3 read as 0.
- R11: While status bit 1 is set, messages that arrive do not write the buffer and do not change status bits 1 and 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_bit | input | 1 | Serial data-link bit |
| rx_valid | input | 1 | Qualifies `rx_bit` in this cycle |
| reg_addr | input | 2 | Register select: 0 control, 1 status |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; clear-on-read takes effect at the clock edge |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data for the current `reg_addr` |
| buf_addr | input | 7 | Payload buffer read address |
| buf_rdata | output | 8 | Payload buffer data at `buf_addr` |
| irq | output | 1 | Interrupt; equals control bit 0 |

## Verification
The hardest case to reach is the buffer lock: a second, fully valid message has to arrive while the first is still unread. The bench reaches it by sending a good message and leaving the status register unread. It then sends a different good message and reads the buffer back to confirm it still holds the first payload. After that it reads the status register and resends the second message, which must then be accepted. The zero-deletion path is exercised by payloads that contain 0x7E and 0xFF, and an abort is made by sending eight raw ones in the middle of a message.

// File: rtl/lapd_rx_pkg.sv
package lapd_rx_pkg;

    localparam int OCT_W        = 8;
    localparam int BUF_DEPTH    = 82;
    localparam int BUF_AW       = 7;
    localparam int REG_AW       = 2;
    localparam int HDR_OCTS     = 3;
    localparam int FCS_OCTS     = 2;
    localparam int CNT_W        = 8;

    localparam logic [REG_AW-1:0] REG_CTRL = 2'd0;
    localparam logic [REG_AW-1:0] REG_STAT = 2'd1;

    localparam logic [7:0] HDR0_A   = 8'h3C;
    localparam logic [7:0] HDR0_B   = 8'h3E;
    localparam logic [7:0] HDR1_VAL = 8'h01;
    localparam logic [7:0] HDR2_VAL = 8'h03;

    localparam logic [7:0] TYPE_PATH_SHORT = 8'h38;
    localparam logic [7:0] TYPE_IDLE       = 8'h34;
    localparam logic [7:0] TYPE_TEST       = 8'h32;
    localparam logic [7:0] TYPE_PATH_LONG  = 8'h3F;
    localparam int         LEN_SHORT       = 76;
    localparam int         LEN_LONG        = 82;

    localparam logic [15:0] CRC_PRESET  = 16'hFFFF;
    localparam logic [15:0] CRC_RESIDUE = 16'hF0B8;
    localparam logic [15:0] CRC_POLY_R  = 16'h8408;

    // one-cycle events from the bit layer to the octet layer
    typedef struct packed {
        logic             flag;
        logic             aligned;
        logic             abort;
        logic             oct_vld;
        logic [OCT_W-1:0] oct;
    } dl_evt_t;

    typedef struct packed {
        logic            known;
        logic [CNT_W-1:0] len;
    } msg_kind_t;

    function automatic logic [15:0] crc16_octet(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r;
        r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ CRC_POLY_R;
            else             r = r >> 1;
        end
        return r;
    endfunction

    function automatic msg_kind_t decode_kind(input logic [7:0] t);
        msg_kind_t k;
        k.known = 1'b1;
        k.len   = CNT_W'(LEN_SHORT);
        case (t)
            TYPE_PATH_SHORT, TYPE_IDLE, TYPE_TEST: k.len = CNT_W'(LEN_SHORT);
            TYPE_PATH_LONG:                        k.len = CNT_W'(LEN_LONG);
            default: begin
                k.known = 1'b0;
                k.len   = '0;
            end
        endcase
        return k;
    endfunction

endpackage

// File: rtl/lapd_bit_deframer.sv
module lapd_bit_deframer
    import lapd_rx_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    en,
    input  logic    bit_i,
    input  logic    vld_i,
    output dl_evt_t evt
);
    logic [2:0]       ones_q, ones_d;
    logic [2:0]       cnt_q, cnt_d;
    logic [OCT_W-1:0] sh_q, sh_d;
    logic             dat_vld;

    always_comb begin
        evt     = '0;
        ones_d  = ones_q;
        cnt_d   = cnt_q;
        sh_d    = sh_q;
        dat_vld = 1'b0;
        if (vld_i) begin
            if (bit_i) begin
                if (ones_q >= 3'd6) begin
                    evt.abort = 1'b1;
                    ones_d    = 3'd7;
                    cnt_d     = '0;
                end else begin
                    ones_d  = ones_q + 3'd1;
                    dat_vld = (ones_q < 3'd5);
                end
            end else begin
                ones_d = '0;
                if (ones_q == 3'd6) begin
                    evt.flag    = 1'b1;
                    evt.aligned = (cnt_q == 3'd6);
                    cnt_d       = '0;
                end else if (ones_q < 3'd5) begin
                    dat_vld = 1'b1;
                end
            end
        end
        if (dat_vld) begin
            sh_d = {bit_i, sh_q[OCT_W-1:1]};
            if (cnt_q == 3'd7) begin
                evt.oct_vld = 1'b1;
                evt.oct     = sh_d;
                cnt_d       = '0;
            end else begin
                cnt_d = cnt_q + 3'd1;
            end
        end
        if (!en) evt = '0;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            ones_q <= '0;
            cnt_q  <= '0;
            sh_q   <= '0;
        end else begin
            ones_q <= ones_d;
            cnt_q  <= cnt_d;
            sh_q   <= sh_d;
        end
    end
endmodule

// File: rtl/lapd_octet_parser.sv
module lapd_octet_parser
    import lapd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  dl_evt_t           evt,
    input  logic              lock,
    output logic              buf_we,
    output logic [BUF_AW-1:0] buf_waddr,
    output logic [OCT_W-1:0]  buf_wdata,
    output logic              accept_p,
    output logic              reject_p
);
    localparam logic [CNT_W-1:0] CNT_MAX  = '1;
    localparam logic [CNT_W-1:0] PAY_BASE = CNT_W'(HDR_OCTS);
    localparam logic [CNT_W-1:0] PAY_END  = CNT_W'(HDR_OCTS + BUF_DEPTH);
    localparam logic [CNT_W-1:0] OVERHEAD = CNT_W'(HDR_OCTS + FCS_OCTS);

    logic             in_q, in_d;
    logic             skip_q, skip_d;
    logic             hdr_q, hdr_d;
    logic [CNT_W-1:0] n_q, n_d;
    logic [15:0]      crc_q, crc_d;
    msg_kind_t        kind_q, kind_d;
    logic             ignore, good;

    assign ignore = skip_q | lock;

    always_comb begin
        in_d      = in_q;
        skip_d    = skip_q | lock;
        hdr_d     = hdr_q;
        n_d       = n_q;
        crc_d     = crc_q;
        kind_d    = kind_q;
        buf_we    = 1'b0;
        buf_waddr = '0;
        buf_wdata = evt.oct;
        accept_p  = 1'b0;
        reject_p  = 1'b0;
        good      = hdr_q && kind_q.known && (crc_q == CRC_RESIDUE)
                    && (n_q == kind_q.len + OVERHEAD) && evt.aligned;
        if (evt.abort) begin
            reject_p = in_q && (n_q != '0) && !ignore;
            in_d     = 1'b0;
        end else if (evt.flag) begin
            if (in_q && (n_q != '0) && !ignore) begin
                accept_p = good;
                reject_p = !good;
            end
            in_d   = 1'b1;
            skip_d = lock;
            hdr_d  = 1'b1;
            n_d    = '0;
            crc_d  = CRC_PRESET;
            kind_d = '0;
        end else if (evt.oct_vld && in_q) begin
            crc_d = crc16_octet(crc_q, evt.oct);
            if (n_q != CNT_MAX) n_d = n_q + 1'b1;
            case (n_q)
                8'd0:    if (evt.oct != HDR0_A && evt.oct != HDR0_B) hdr_d = 1'b0;
                8'd1:    if (evt.oct != HDR1_VAL) hdr_d = 1'b0;
                8'd2:    if (evt.oct != HDR2_VAL) hdr_d = 1'b0;
                8'd3:    kind_d = decode_kind(evt.oct);
                default: ;
            endcase
            if (n_q >= PAY_BASE && n_q < PAY_END && !ignore) begin
                buf_we    = 1'b1;
                buf_waddr = BUF_AW'(n_q - PAY_BASE);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            in_q   <= 1'b0;
            skip_q <= 1'b0;
            hdr_q  <= 1'b0;
            n_q    <= '0;
            crc_q  <= CRC_PRESET;
            kind_q <= '0;
        end else begin
            in_q   <= in_d;
            skip_q <= skip_d;
            hdr_q  <= hdr_d;
            n_q    <= n_d;
            crc_q  <= crc_d;
            kind_q <= kind_d;
        end
    end
endmodule

// File: rtl/lapd_payload_buf.sv
module lapd_payload_buf #(
    parameter int DEPTH = 82,
    parameter int AW    = 7,
    parameter int W     = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr,
    output logic [W-1:0]  rdata
);
    logic [W-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we && (int'(waddr) < DEPTH)) mem[waddr] <= wdata;
    end

    assign rdata = (int'(raddr) < DEPTH) ? mem[raddr] : '0;
endmodule

// File: rtl/lapd_msg_rx.sv
module lapd_msg_rx
    import lapd_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rx_bit,
    input  logic              rx_valid,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    input  logic [BUF_AW-1:0] buf_addr,
    output logic [OCT_W-1:0]  buf_rdata,
    output logic              irq
);
    logic              en_q, irq_en_q, int_q;
    logic              flag_seen_q, msg_ok_q, msg_err_q;
    logic              rd_ctrl, rd_stat, lock;
    dl_evt_t           evt;
    logic              flag_p, abort_p, accept_p, reject_p;
    logic              buf_we;
    logic [BUF_AW-1:0] buf_waddr;
    logic [OCT_W-1:0]  buf_wdata;

    lapd_bit_deframer u_deframer (
        .clk   (clk),
        .rst   (rst),
        .en    (en_q),
        .bit_i (rx_bit),
        .vld_i (rx_valid),
        .evt   (evt)
    );

    assign flag_p  = evt.flag;
    assign abort_p = evt.abort;
    assign lock    = msg_ok_q;

    lapd_octet_parser u_parser (
        .clk       (clk),
        .rst       (rst),
        .en        (en_q),
        .evt       (evt),
        .lock      (lock),
        .buf_we    (buf_we),
        .buf_waddr (buf_waddr),
        .buf_wdata (buf_wdata),
        .accept_p  (accept_p),
        .reject_p  (reject_p)
    );

    lapd_payload_buf #(
        .DEPTH (BUF_DEPTH),
        .AW    (BUF_AW),
        .W     (OCT_W)
    ) u_buf (
        .clk   (clk),
        .we    (buf_we),
        .waddr (buf_waddr),
        .wdata (buf_wdata),
        .raddr (buf_addr),
        .rdata (buf_rdata)
    );

    assign rd_ctrl = reg_rd && (reg_addr == REG_CTRL);
    assign rd_stat = reg_rd && (reg_addr == REG_STAT);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q        <= 1'b0;
            irq_en_q    <= 1'b0;
            int_q       <= 1'b0;
            flag_seen_q <= 1'b0;
            msg_ok_q    <= 1'b0;
            msg_err_q   <= 1'b0;
        end else begin
            if (reg_wr && (reg_addr == REG_CTRL)) begin
                en_q     <= reg_wdata[2];
                irq_en_q <= reg_wdata[1];
            end
            int_q       <= (int_q && !rd_ctrl) || (accept_p && irq_en_q);
            flag_seen_q <= (flag_seen_q && !rd_stat) || flag_p;
            msg_ok_q    <= (msg_ok_q && !rd_stat) || accept_p;
            msg_err_q   <= (msg_err_q && !rd_stat) || reject_p;
        end
    end

    always_comb begin
        case (reg_addr)
            REG_CTRL: reg_rdata = {5'b0, en_q, irq_en_q, int_q};
            REG_STAT: reg_rdata = {5'b0, msg_err_q, msg_ok_q, flag_seen_q};
            default:  reg_rdata = '0;
        endcase
    end

    assign irq = int_q;
endmodule

// File: rtl/lapd_msg_rx_chk.sv
module lapd_msg_rx_chk (
    input logic       clk,
    input logic       rst,
    input logic       en_q,
    input logic       irq_en_q,
    input logic       irq,
    input logic       flag_p,
    input logic       abort_p,
    input logic       accept_p,
    input logic       reject_p,
    input logic       buf_we,
    input logic       lock,
    input logic [1:0] reg_addr,
    input logic [7:0] reg_rdata
);
    AST_DISABLED_NO_FLAG: assert property (@(posedge clk) disable iff (rst)
        !en_q |-> !flag_p); // R1

    AST_FLAG_ABORT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(flag_p && abort_p)); // R7

    AST_ACCEPT_REJECT_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(accept_p && reject_p)); // R8

    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(irq_en_q) && $past(accept_p)); // R9

    AST_UPPER_BITS_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_addr < 2'd2) |-> (reg_rdata[7:3] == 5'd0)); // R10

    AST_LOCK_NO_WRITE: assert property (@(posedge clk) disable iff (rst)
        lock |-> !buf_we); // R11

    AST_LOCK_NO_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        lock |-> !accept_p && !reject_p); // R11
endmodule

bind lapd_msg_rx lapd_msg_rx_chk u_chk (
    .clk       (clk),
    .rst       (rst),
    .en_q      (en_q),
    .irq_en_q  (irq_en_q),
    .irq       (irq),
    .flag_p    (flag_p),
    .abort_p   (abort_p),
    .accept_p  (accept_p),
    .reject_p  (reject_p),
    .buf_we    (buf_we),
    .lock      (lock),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata)
);

// File: tb/lapd_msg_rx_bench.sv
module lapd_msg_rx_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rx_bit = 1'b0;
    logic       rx_valid = 1'b0;
    logic [1:0] reg_addr = 2'd0;
    logic       reg_wr = 1'b0;
    logic       reg_rd = 1'b0;
    logic [7:0] reg_wdata = 8'd0;
    logic [7:0] reg_rdata;
    logic [6:0] buf_addr = 7'd0;
    logic [7:0] buf_rdata;
    logic       irq;

    int checks = 0;
    int errors = 0;
    int tx_ones = 0;

    logic [7:0] frm [0:99];
    int         frm_n;
    logic [7:0] exp_pay [0:81];
    int         exp_len;

    always #2 clk = ~clk;

    lapd_msg_rx u_lapd_msg_rx (
        .clk       (clk),
        .rst       (rst),
        .rx_bit    (rx_bit),
        .rx_valid  (rx_valid),
        .reg_addr  (reg_addr),
        .reg_wr    (reg_wr),
        .reg_rd    (reg_rd),
        .reg_wdata (reg_wdata),
        .reg_rdata (reg_rdata),
        .buf_addr  (buf_addr),
        .buf_rdata (buf_rdata),
        .irq       (irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
        end
    endtask

    task automatic wr_reg(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a; reg_rd = 1'b1;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
    endtask

    task automatic raw_bit(input logic b);
        @(negedge clk);
        rx_bit = b; rx_valid = 1'b1;
    endtask

    task automatic idle(input int n);
        @(negedge clk);
        rx_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic send_flag();
        logic [7:0] f = 8'h7E;
        for (int i = 0; i < 8; i++) raw_bit(f[i]);
        tx_ones = 0;
    endtask

    task automatic send_abort();
        for (int i = 0; i < 8; i++) raw_bit(1'b1);
        tx_ones = 0;
    endtask

    task automatic send_octet(input logic [7:0] d);
        for (int i = 0; i < 8; i++) begin
            raw_bit(d[i]);
            if (d[i]) begin
                tx_ones++;
                if (tx_ones == 5) begin
                    raw_bit(1'b0);
                    tx_ones = 0;
                end
            end else begin
                tx_ones = 0;
            end
        end
    endtask

    function automatic logic [15:0] ref_crc(input logic [15:0] c, input logic [7:0] d);
        logic [15:0] r = c;
        for (int i = 0; i < 8; i++) begin
            if (r[0] ^ d[i]) r = (r >> 1) ^ 16'h8408;
            else             r = r >> 1;
        end
        return r;
    endfunction

    // header, payload (type in byte 0), then check octets
    task automatic build(input logic [7:0] h0, input logic [7:0] h1, input logic [7:0] h2,
                         input logic [7:0] typ, input int len, input logic [7:0] seed,
                         input logic bad_fcs);
        logic [15:0] c = 16'hFFFF;
        logic [15:0] fcs;
        frm[0] = h0; frm[1] = h1; frm[2] = h2;
        for (int i = 0; i < len; i++) begin
            logic [7:0] v;
            v = 8'(int'(seed) + i * 29);
            if (i == 0) v = typ;
            if (i == 5) v = 8'h7E;
            if (i == 6 || i == 7) v = 8'hFF;
            frm[3 + i] = v;
            if (i < 82) exp_pay[i] = v;
        end
        exp_len = len;
        for (int i = 0; i < 3 + len; i++) c = ref_crc(c, frm[i]);
        fcs = ~c;
        if (bad_fcs) fcs[4] = ~fcs[4];
        frm[3 + len] = fcs[7:0];
        frm[4 + len] = fcs[15:8];
        frm_n = 5 + len;
    endtask

    task automatic xmit();
        send_flag();
        for (int i = 0; i < frm_n; i++) send_octet(frm[i]);
        send_flag();
        idle(6);
    endtask

    task automatic check_buf(input string req, input int n);
        int bad = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_addr = 7'(i);
            #1;
            if (buf_rdata !== exp_pay[i]) begin
                bad++;
                if (bad == 1) $display("FAIL %s: buffer[%0d] got 0x%02h expected 0x%02h",
                                       req, i, buf_rdata, exp_pay[i]);
            end
        end
        checks++;
        if (bad != 0) errors++;
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(2'd0, d); check("R10 control reset", d, 8'h00);
        rd_reg(2'd1, d); check("R2 status reset", d, 8'h00);
        check("R9 irq reset", {7'd0, irq}, 8'h00);
    endtask

    task automatic t_disabled();
        logic [7:0] d;
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h11, 1'b0);
        xmit();
        rd_reg(2'd1, d); check("R1 disabled no status", d, 8'h00);
    endtask

    task automatic t_ctrl_bits();
        logic [7:0] d;
        wr_reg(2'd0, 8'hFF);
        rd_reg(2'd0, d); check("R10 writable bits only", d, 8'h06);
        wr_reg(2'd0, 8'h04);
        rd_reg(2'd0, d); check("R10 enable only", d, 8'h04);
    endtask

    task automatic t_flag_only();
        logic [7:0] d;
        send_flag(); send_flag(); idle(4);
        rd_reg(2'd1, d); check("R2 flag present", d, 8'h01);
        rd_reg(2'd1, d); check("R2 cleared by read", d, 8'h00);
    endtask

    task automatic t_good_short();
        logic [7:0] d;
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h21, 1'b0);
        xmit();
        check_buf("R3 R8 short payload", 76);
        check("R9 irq stays low when disabled", {7'd0, irq}, 8'h00);
        rd_reg(2'd1, d); check("R8 accept status", d, 8'h03);
    endtask

    task automatic t_good_long_irq();
        logic [7:0] d;
        wr_reg(2'd0, 8'h06);
        build(8'h3E, 8'h01, 8'h03, 8'h3F, 82, 8'h47, 1'b0);
        xmit();
        check("R9 irq raised", {7'd0, irq}, 8'h01);
        rd_reg(2'd0, d); check("R9 control int bit", d, 8'h07);
        rd_reg(2'd0, d); check("R9 int cleared by read", d, 8'h06);
        check("R9 irq cleared", {7'd0, irq}, 8'h00);
        check_buf("R5 long payload", 82);
        rd_reg(2'd1, d); check("R8 long accept", d, 8'h03);
        wr_reg(2'd0, 8'h04);
    endtask

    task automatic t_reject(input string req, input logic [7:0] h0, input logic [7:0] h2,
                            input logic [7:0] typ, input int len, input logic bad);
        logic [7:0] d;
        build(h0, 8'h01, h2, typ, len, 8'h5A, bad);
        xmit();
        rd_reg(2'd1, d); check(req, d, 8'h05);
    endtask

    task automatic t_other_types();
        logic [7:0] d;
        build(8'h3C, 8'h01, 8'h03, 8'h34, 76, 8'h02, 1'b0);
        xmit();
        rd_reg(2'd1, d); check("R5 type 0x34 accepted", d, 8'h03);
        build(8'h3E, 8'h01, 8'h03, 8'h32, 76, 8'h03, 1'b0);
        xmit();
        rd_reg(2'd1, d); check("R5 type 0x32 accepted", d, 8'h03);
    endtask

    task automatic t_abort();
        logic [7:0] d;
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h09, 1'b0);
        send_flag();
        for (int i = 0; i < 10; i++) send_octet(frm[i]);
        send_abort();
        idle(4);
        rd_reg(2'd1, d); check("R7 abort rejects", d, 8'h05);
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h0A, 1'b0);
        xmit();
        rd_reg(2'd1, d); check("R7 recovery after abort", d, 8'h03);
    endtask

    task automatic t_lock();
        logic [7:0] d;
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h61, 1'b0);
        xmit();
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h61, 1'b0);
        build(8'h3C, 8'h01, 8'h03, 8'h34, 76, 8'hA3, 1'b0);
        xmit();
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h61, 1'b0);
        check_buf("R11 buffer held while locked", 76);
        build(8'h3C, 8'h01, 8'h03, 8'h38, 76, 8'h61, 1'b1);
        xmit();
        rd_reg(2'd1, d); check("R11 status unchanged while locked", d, 8'h03);
        build(8'h3C, 8'h01, 8'h03, 8'h34, 76, 8'hA3, 1'b0);
        xmit();
        check_buf("R11 buffer refilled after read", 76);
        rd_reg(2'd1, d); check("R11 accepted after unlock", d, 8'h03);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_disabled();
        t_ctrl_bits();
        t_flag_only();
        t_good_short();
        t_good_long_irq();
        t_reject("R6 bad check sequence", 8'h3C, 8'h03, 8'h38, 76, 1'b1);
        t_reject("R4 bad control octet", 8'h3C, 8'h13, 8'h38, 76, 1'b0);
        t_reject("R4 bad first address octet", 8'h3D, 8'h03, 8'h38, 76, 1'b0);
        t_reject("R5 length mismatch", 8'h3C, 8'h03, 8'h38, 82, 1'b0);
        t_reject("R5 unknown type", 8'h3C, 8'h03, 8'h30, 76, 1'b0);
        t_other_types();
        t_abort();
        t_lock();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule